// File: doc/BRIEF.md
# Dual-Channel Wiper and Data Register Bank

This block keeps the register state behind a two-channel digitally controlled potentiometer. Each channel owns one volatile 8-bit wiper code and four 8-bit data registers that stand in for persistent storage. A serial front end, not part of this block, decodes frames into single-cycle command strobes. Each strobe carries an opcode, a channel index, a data-register index and a data byte. The bank carries out the command and returns read data. It presents both wiper codes and, optionally, a one-hot 256-way tap select for each channel.

The wiper code can change in four ways: a direct host write, a copy from one of the channel's data registers, a single up or down step, or the automatic recall of data register 0 after reset. Global copies act on both channels in the same cycle. Any command that changes a data register is a persistent write. It raises a one-cycle start request to an external write timer. While that timer reports busy, further persistent requests are dropped, but reads and wiper loads still execute.

Opcodes on `cmd_op_i`: 1 read wiper, 2 write wiper, 3 read data register, 4 write data register, 5 copy data register to wiper, 6 copy wiper to data register, 7 global copy of data registers to wipers, 8 global copy of wipers to data registers, 9 step. For a step, `cmd_data_i[0]` = 1 moves toward the high end and 0 moves toward the low end. All other codes do nothing. Channel 0 appears on `wiper_o[7:0]` and channel 1 on `wiper_o[15:8]`. Data register r of channel c sits at bits `(c*4+r)*8 +: 8` of the initial-content parameter.

Top module: `wiper_bank`

## Requirements
- R1: While `rst_ni` is low, both wiper codes, `rd_data_o` and `nv_start_o` are 0. At the first clock edge after release, each wiper code loads its channel's data register 0, and any command presented in that cycle is ignored. Data registers keep their contents across reset.
- R2: Opcode 2 loads `cmd_data_i` into the wiper of channel `cmd_ch_i`; the new code is visible after the next edge. The other channel is unchanged.
- R3: Opcode 4 stores `cmd_data_i` into data register `cmd_reg_i` of channel `cmd_ch_i`. `nv_start_o` is high for exactly the one cycle after the accepting edge.
- R4: Opcode 1 returns the wiper of the selected channel, and opcode 3 returns the selected data register, on `rd_data_o` after the next edge. `rd_data_o` holds its value otherwise.
- R5: Opcode 5 copies the selected data register into its channel's wiper.
- R6: Opcode 6 copies the selected channel's wiper into its data register `cmd_reg_i` and pulses `nv_start_o`.
- R7: Opcode 7 copies data register `cmd_reg_i` of each channel into that channel's wiper in the same edge.
- R8: Opcode 8 copies each wiper into data register `cmd_reg_i` of its own channel in the same edge, with a single `nv_start_o` pulse.
- R9: Opcode 9 moves the selected wiper up by one when `cmd_data_i[0]` is 1 and down by one when it is 0.
- R10: A step up at 8'hFF leaves the code at 8'hFF, and a step down at 8'h00 leaves it at 8'h00.
- R11: A persistent request (opcode 4, 6 or 8) made while `nv_busy_i` is high or `nv_start_o` is high changes no data register and raises no `nv_start_o`. Reads and wiper loads still execute in that state.
- R12: For each channel, exactly one tap-select bit is high, at the bit index equal to the wiper code. Code 8'h00 selects bit 0 (low end) and 8'hFF selects bit 255 (high end).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | Command strobe, one cycle per command |
| cmd_op_i | input | 4 | Opcode |
| cmd_ch_i | input | 1 | Channel index |
| cmd_reg_i | input | 2 | Data register index |
| cmd_data_i | input | 8 | Write data; bit 0 gives the step direction |
| nv_busy_i | input | 1 | External write timer busy |
| nv_start_o | output | 1 | One-cycle persistent write start request |
| rd_data_o | output | 8 | Read data |
| wiper_o | output | 16 | Wiper codes, channel 0 in the low byte |
| tap_sel_o | output | 512 | One-hot tap selects, channel 0 in the low 256 bits |

## Verification
The bound checker checks these on every cycle: tap selects stay one-hot and aligned with the wiper code, the recall loads data register 0, host wiper writes land, steps saturate at both ends, the start request never lasts two cycles, and requests made while busy never start a write. Other behaviour is shown only by the bench's directed scenarios. That covers data-register contents after single and global copies, persistence across a second reset, and dropped writes, which are seen through later reads. It also covers the start request being refused in the cycle right after a write was accepted.

// File: rtl/wbank_pkg.sv
package wbank_pkg;
  typedef enum logic [3:0] {
    OP_NOP     = 4'd0,
    OP_RD_WP   = 4'd1,
    OP_WR_WP   = 4'd2,
    OP_RD_DR   = 4'd3,
    OP_WR_DR   = 4'd4,
    OP_DR2WP   = 4'd5,
    OP_WP2DR   = 4'd6,
    OP_G_DR2WP = 4'd7,
    OP_G_WP2DR = 4'd8,
    OP_STEP    = 4'd9
  } wb_op_e;
endpackage

// File: rtl/wbank_store.sv
module wbank_store #(
  parameter int NCH = 2,
  parameter int NDR = 4,
  parameter int W   = 8,
  parameter logic [NCH*NDR*W-1:0] DR_INIT = '0,
  localparam int RW = (NDR > 1) ? $clog2(NDR) : 1
) (
  input  logic                           clk_i,
  input  logic [NCH-1:0]                 we_i,
  input  logic [RW-1:0]                  idx_i,
  input  logic [NCH-1:0][W-1:0]          wdata_i,
  output logic [NCH-1:0][NDR-1:0][W-1:0] dr_o
);
  // no reset: contents model persistent cells
  logic [NCH-1:0][NDR-1:0][W-1:0] dr_q = DR_INIT;

  always_ff @(posedge clk_i) begin
    for (int c = 0; c < NCH; c++) begin
      if (we_i[c]) dr_q[c][idx_i] <= wdata_i[c];
    end
  end

  assign dr_o = dr_q;
endmodule

// File: rtl/wbank_wiper.sv
module wbank_wiper #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         recall_i,
  input  logic [W-1:0] recall_val_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         step_i,
  input  logic         step_up_i,
  output logic [W-1:0] wiper_o
);
  localparam logic [W-1:0] MAX = {W{1'b1}};
  logic [W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        q <= '0;
    else if (recall_i)  q <= recall_val_i;
    else if (load_i)    q <= load_val_i;
    else if (step_i) begin
      if (step_up_i && q != MAX)      q <= q + 1'b1;
      else if (!step_up_i && q != '0) q <= q - 1'b1;
    end
  end

  assign wiper_o = q;
endmodule

// File: rtl/wbank_tap_decode.sv
module wbank_tap_decode #(
  parameter int W = 8,
  localparam int T = 1 << W
) (
  input  logic [W-1:0] code_i,
  output logic [T-1:0] tap_o
);
  always_comb begin
    tap_o = '0;
    tap_o[code_i] = 1'b1;
  end
endmodule

// File: rtl/wiper_bank.sv
module wiper_bank
  import wbank_pkg::*;
#(
  parameter int NCH = 2,
  parameter int NDR = 4,
  parameter int W   = 8,
  parameter bit TAP_DECODE = 1'b1,
  parameter logic [NCH*NDR*W-1:0] DR_INIT = '0,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int RW = (NDR > 1) ? $clog2(NDR) : 1,
  localparam int T  = 1 << W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  input  logic [3:0]       cmd_op_i,
  input  logic [CW-1:0]    cmd_ch_i,
  input  logic [RW-1:0]    cmd_reg_i,
  input  logic [W-1:0]     cmd_data_i,
  input  logic             nv_busy_i,
  output logic             nv_start_o,
  output logic [W-1:0]     rd_data_o,
  output logic [NCH*W-1:0] wiper_o,
  output logic [NCH*T-1:0] tap_sel_o
);
  wb_op_e op;
  assign op = wb_op_e'(cmd_op_i);

  logic recall_q, nv_start_q, nv_lock, act;
  logic [NCH-1:0][NDR-1:0][W-1:0] dr_all;
  logic [NCH-1:0][W-1:0] wiper, wp_val, dr_wval;
  logic [NCH-1:0] wp_load, wp_step, dr_we;
  logic [W-1:0] rd_q;

  assign act     = cmd_valid_i && !recall_q;
  assign nv_lock = nv_busy_i || nv_start_q;

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      logic sel;
      sel        = (cmd_ch_i == CW'(c));
      wp_load[c] = act && (((op == OP_WR_WP || op == OP_DR2WP) && sel) || op == OP_G_DR2WP);
      wp_val[c]  = (op == OP_WR_WP) ? cmd_data_i : dr_all[c][cmd_reg_i];
      wp_step[c] = act && op == OP_STEP && sel;
      dr_we[c]   = act && !nv_lock &&
                   (((op == OP_WR_DR || op == OP_WP2DR) && sel) || op == OP_G_WP2DR);
      dr_wval[c] = (op == OP_WR_DR) ? cmd_data_i : wiper[c];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      recall_q   <= 1'b1;
      nv_start_q <= 1'b0;
      rd_q       <= '0;
    end else begin
      recall_q   <= 1'b0;
      nv_start_q <= |dr_we;
      if (act && op == OP_RD_WP)      rd_q <= wiper[cmd_ch_i];
      else if (act && op == OP_RD_DR) rd_q <= dr_all[cmd_ch_i][cmd_reg_i];
    end
  end

  wbank_store #(.NCH(NCH), .NDR(NDR), .W(W), .DR_INIT(DR_INIT)) u_store (
    .clk_i   (clk_i),
    .we_i    (dr_we),
    .idx_i   (cmd_reg_i),
    .wdata_i (dr_wval),
    .dr_o    (dr_all)
  );

  for (genvar c = 0; c < NCH; c++) begin : gen_ch
    wbank_wiper #(.W(W)) u_wiper (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .recall_i     (recall_q),
      .recall_val_i (dr_all[c][0]),
      .load_i       (wp_load[c]),
      .load_val_i   (wp_val[c]),
      .step_i       (wp_step[c]),
      .step_up_i    (cmd_data_i[0]),
      .wiper_o      (wiper[c])
    );
    if (TAP_DECODE) begin : gen_tap
      wbank_tap_decode #(.W(W)) u_tap (
        .code_i (wiper[c]),
        .tap_o  (tap_sel_o[c*T +: T])
      );
    end else begin : gen_no_tap
      assign tap_sel_o[c*T +: T] = '0;
    end
  end

  assign wiper_o    = wiper;
  assign rd_data_o  = rd_q;
  assign nv_start_o = nv_start_q;
endmodule

// File: rtl/wiper_bank_chk.sv
module wiper_bank_chk #(
  parameter int NCH = 2,
  parameter int NDR = 4,
  parameter int W   = 8,
  parameter bit TAP_DECODE = 1'b1,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int T  = 1 << W
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic                           cmd_valid_i,
  input logic [3:0]                     cmd_op_i,
  input logic [CW-1:0]                  cmd_ch_i,
  input logic [W-1:0]                   cmd_data_i,
  input logic                           nv_busy_i,
  input logic                           nv_start_o,
  input logic [NCH*W-1:0]               wiper_o,
  input logic [NCH*T-1:0]               tap_sel_o,
  input logic                           recall_q,
  input logic [NCH-1:0][NDR-1:0][W-1:0] dr_all
);
  localparam logic [W-1:0] MAX = {W{1'b1}};

  // R1
  recall_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    recall_q |=> wiper_o[W-1:0] == $past(dr_all[0][0]));

  // R2
  wiper_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && !recall_q && cmd_op_i == 4'd2 && cmd_ch_i == '0)
      |=> wiper_o[W-1:0] == $past(cmd_data_i));

  // R3
  start_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nv_start_o |=> !nv_start_o);

  // R10
  sat_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && !recall_q && cmd_op_i == 4'd9 && cmd_ch_i == '0 &&
     cmd_data_i[0] && wiper_o[W-1:0] == MAX) |=> wiper_o[W-1:0] == MAX);

  // R10
  sat_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && !recall_q && cmd_op_i == 4'd9 && cmd_ch_i == '0 &&
     !cmd_data_i[0] && wiper_o[W-1:0] == '0) |=> wiper_o[W-1:0] == '0);

  // R11
  busy_reject_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && nv_busy_i) |=> !nv_start_o);

  if (TAP_DECODE) begin : gen_tap_chk
    for (genvar c = 0; c < NCH; c++) begin : gen_c
      // R12
      tap_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $countones(tap_sel_o[c*T +: T]) == 1 &&
        tap_sel_o[c*T + int'(wiper_o[c*W +: W])]);
    end
  end
endmodule

bind wiper_bank wiper_bank_chk #(.NCH(NCH), .NDR(NDR), .W(W), .TAP_DECODE(TAP_DECODE)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_valid_i (cmd_valid_i),
  .cmd_op_i    (cmd_op_i),
  .cmd_ch_i    (cmd_ch_i),
  .cmd_data_i  (cmd_data_i),
  .nv_busy_i   (nv_busy_i),
  .nv_start_o  (nv_start_o),
  .wiper_o     (wiper_o),
  .tap_sel_o   (tap_sel_o),
  .recall_q    (recall_q),
  .dr_all      (dr_all)
);

// File: tb/tb_wiper_bank.sv
`timescale 1ns/1ps
module tb_wiper_bank;
  logic         clk = 0;
  logic         rst_n = 0;
  logic         valid = 0;
  logic [3:0]   op = 0;
  logic         ch = 0;
  logic [1:0]   rg = 0;
  logic [7:0]   data = 0;
  logic         busy = 0;
  logic         nv_start;
  logic [7:0]   rd;
  logic [15:0]  wiper;
  logic [511:0] tap;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  wiper_bank #(.DR_INIT(64'h000000C3_0000005A)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(valid), .cmd_op_i(op),
    .cmd_ch_i(ch), .cmd_reg_i(rg), .cmd_data_i(data), .nv_busy_i(busy),
    .nv_start_o(nv_start), .rd_data_o(rd), .wiper_o(wiper), .tap_sel_o(tap)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one command across one rising edge; returns at the following falling edge
  task automatic cmd(input logic [3:0] o, input logic c, input logic [1:0] r, input logic [7:0] d);
    valid = 1; op = o; ch = c; rg = r; data = d;
    @(negedge clk);
    valid = 0; op = 0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic rd_dr(input logic c, input logic [1:0] r, input string req, input logic [7:0] exp);
    cmd(4'd3, c, r, 8'h00);
    check(req, rd, exp);
  endtask

  task automatic check_taps(input string req);
    for (int c = 0; c < 2; c++) begin
      logic [255:0] exp;
      exp = 256'd1 << wiper[c*8 +: 8];
      check(req, {31'd0, tap[c*256 +: 256] == exp}, 32'd1);
      check(req, $countones(tap[c*256 +: 256]), 32'd1);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 wiper in reset", wiper, 16'h0000);
    check("R1 rd in reset", rd, 8'h00);
    check("R1 start in reset", nv_start, 1'b0);
    rst_n = 1;
    cmd(4'd2, 1'b0, 2'd0, 8'h11); // lands in recall cycle: ignored
    check("R1 recall", wiper, 16'hC35A);
    check_taps("R12 after recall");
  endtask

  task automatic t_wiper_write();
    cmd(4'd2, 1'b1, 2'd0, 8'h77);
    check("R2 write ch1", wiper[15:8], 8'h77);
    check("R2 ch0 untouched", wiper[7:0], 8'h5A);
    check_taps("R12 after write");
  endtask

  task automatic t_read();
    cmd(4'd1, 1'b1, 2'd0, 8'h00);
    check("R4 read wiper", rd, 8'h77);
    idle();
    check("R4 rd holds", rd, 8'h77);
    rd_dr(1'b0, 2'd0, "R4 read DR", 8'h5A);
  endtask

  task automatic t_dr_write();
    cmd(4'd4, 1'b0, 2'd2, 8'h3C);
    check("R3 start pulse", nv_start, 1'b1);
    idle();
    check("R3 start ends", nv_start, 1'b0);
    rd_dr(1'b0, 2'd2, "R3 DR stored", 8'h3C);
  endtask

  task automatic t_xfer();
    cmd(4'd5, 1'b0, 2'd2, 8'h00);
    check("R5 DR to wiper", wiper[7:0], 8'h3C);
    cmd(4'd6, 1'b1, 2'd3, 8'h00);
    check("R6 start pulse", nv_start, 1'b1);
    idle();
    rd_dr(1'b1, 2'd3, "R6 wiper to DR", 8'h77);
  endtask

  task automatic t_global();
    cmd(4'd4, 1'b0, 2'd1, 8'h10); idle();
    cmd(4'd4, 1'b1, 2'd1, 8'h20); idle();
    cmd(4'd7, 1'b0, 2'd1, 8'h00);
    check("R7 global load", wiper, 16'h2010);
    cmd(4'd2, 1'b0, 2'd0, 8'hAA);
    cmd(4'd8, 1'b1, 2'd3, 8'h00);
    check("R8 start pulse", nv_start, 1'b1);
    idle();
    check("R8 single pulse", nv_start, 1'b0);
    rd_dr(1'b0, 2'd3, "R8 ch0 stored", 8'hAA);
    rd_dr(1'b1, 2'd3, "R8 ch1 stored", 8'h20);
  endtask

  task automatic t_step();
    cmd(4'd2, 1'b0, 2'd0, 8'h80);
    cmd(4'd9, 1'b0, 2'd0, 8'h01);
    check("R9 step up", wiper[7:0], 8'h81);
    cmd(4'd9, 1'b0, 2'd0, 8'h00);
    cmd(4'd9, 1'b0, 2'd0, 8'h00);
    check("R9 step down", wiper[7:0], 8'h7F);
    check("R9 other ch", wiper[15:8], 8'h20);
  endtask

  task automatic t_sat();
    cmd(4'd2, 1'b0, 2'd0, 8'hFF);
    cmd(4'd9, 1'b0, 2'd0, 8'h01);
    check("R10 high end", wiper[7:0], 8'hFF);
    cmd(4'd2, 1'b1, 2'd0, 8'h00);
    cmd(4'd9, 1'b1, 2'd0, 8'h00);
    check("R10 low end", wiper[15:8], 8'h00);
    check_taps("R12 at both ends");
    check("R12 bit255", tap[255], 1'b1);
    check("R12 bit0 ch1", tap[256], 1'b1);
  endtask

  task automatic t_busy();
    busy = 1;
    cmd(4'd4, 1'b0, 2'd0, 8'h99);
    check("R11 no start on write", nv_start, 1'b0);
    cmd(4'd6, 1'b0, 2'd0, 8'h00);
    check("R11 no start on copy", nv_start, 1'b0);
    cmd(4'd2, 1'b0, 2'd0, 8'h44);
    check("R11 wiper load allowed", wiper[7:0], 8'h44);
    rd_dr(1'b0, 2'd0, "R11 DR unchanged", 8'h5A);
    busy = 0;
    cmd(4'd4, 1'b1, 2'd0, 8'h66);
    cmd(4'd4, 1'b1, 2'd0, 8'h67); // during start pulse: dropped
    check("R11 no second pulse", nv_start, 1'b0);
    rd_dr(1'b1, 2'd0, "R11 back-to-back dropped", 8'h66);
  endtask

  task automatic t_recall2();
    rst_n = 0;
    idle();
    check("R1 wiper in reset 2", wiper, 16'h0000);
    rst_n = 1;
    idle();
    check("R1 recall after rewrite", wiper, 16'h665A);
    rd_dr(1'b0, 2'd3, "R1 DR persists", 8'hAA);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_wiper_write();
    t_read();
    t_dr_write();
    t_xfer();
    t_global();
    t_step();
    t_sat();
    t_busy();
    t_recall2();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule